// File: doc/BRIEF.md
# Two-Stage APB Watchdog Timer

This peripheral is a down-counting watchdog with a 32-bit APB slave port. Software programs a reload value, and the counter then steps down by one on each cycle where the watchdog clock-enable input is high. The first time the count runs out, the block raises an interrupt and reloads. If software has not cleared that interrupt by the time the count runs out again, the block latches a reset request and freezes the counter. The system's reset controller is expected to act on that request.

A key-protected lock stops stray writes from touching the timer. An integration-test mode lets the interrupt and reset outputs be driven directly from a register, so the wiring at chip level can be checked. A build parameter selects a second variant. In that variant, the interrupt enable cannot be cleared once it is set, and the test registers do not exist.

Top module: `apb_watchdog`

## Requirements
- R1: After reset, the reload value (word 0x000) and the count (word 0x004) both read 0xFFFFFFFF. Control (0x008), raw status (0x010) and lock (0xC00) read 0. The `irq` and `rst_req` outputs are low. The counter is running.
- R2: A write to 0x000 sets both the reload value and the count to the written data. It also restarts the counter if it was stopped.
- R3: The count drops by exactly one on each clock where `wdog_tick` is high and the counter is running. On other clocks it holds its value.
- R4: When a tick takes the count from 1 to 0 while raw status bit0 is clear, raw status bit0 becomes 1. The next tick reloads the count from the reload value.
- R5: When a tick takes the count from 1 to 0 while raw status bit0 is already set, the reset status is latched and the counter stops at 0. Only a block reset clears the reset status.
- R6: Any write to 0x00C clears raw status bit0 and reloads the count from the reload value.
- R7: `irq` is raw status AND control bit0. `rst_req` is reset status AND control bit1. Word 0x014 reads the value of `irq` in bit0.
- R8: Writing 0x1ACCE551 to 0xC00 unlocks the block, and writing any other value locks it. 0xC00 reads 1 while locked. While locked, writes to every other word are ignored.
- R9: In the base build, while bit0 of 0xF00 is set, `rst_req` follows bit0 of 0xF04 and `irq` follows bit1 of 0xF04. Word 0xF00 reads back its bit0, and word 0xF04 reads 0.
- R10: Words 0xFD0 through 0xFFC read the fixed bytes 04,00,00,00,24,B8,1B,00,0D,F0,05,B1, in that order.
- R11: Reads of write-only or unmapped words return 0. Writes to read-only or unmapped words change nothing.
- R12: With `STICKY_IE`=1, writes to 0x008 are ignored once control bit0 is 1. In that build, words 0xF00 and 0xF04 are invalid: they read 0 and writes to them have no effect.
- R13: Every access completes in its access phase: `pready` is high and `pslverr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| wdog_tick | input | 1 | Counter clock enable |
| irq | output | 1 | Level interrupt |
| rst_req | output | 1 | Reset request |

## Verification
The bench goes after the two expiries back to back. A design that set the reset status on the first expiry, or that did not reload between the two, would show `rst_req` one period early, or never. It reloads with a new value after the counter has stopped. A design that did not restart the counter would stay frozen at 0. It clears the interrupt while the count is part-way down. A design that cleared the status without reloading would then expire early. It writes a lock key that is off by one bit, with a write to every protected word behind it. It also drives the test-mode overrides in both directions, and checks that the sticky enable and the missing test registers of the variant really ignore writes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 12;
    localparam int WIDX_W = ADDR_W - 2;

    localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

    // Word indices (byte offset / 4)
    localparam logic [WIDX_W-1:0] W_LOAD     = 10'h000;
    localparam logic [WIDX_W-1:0] W_VALUE    = 10'h001;
    localparam logic [WIDX_W-1:0] W_CTRL     = 10'h002;
    localparam logic [WIDX_W-1:0] W_ICLR     = 10'h003;
    localparam logic [WIDX_W-1:0] W_RAW      = 10'h004;
    localparam logic [WIDX_W-1:0] W_MASKED   = 10'h005;
    localparam logic [WIDX_W-1:0] W_LOCK     = 10'h300;
    localparam logic [WIDX_W-1:0] W_TCTRL    = 10'h3C0;
    localparam logic [WIDX_W-1:0] W_TOUT     = 10'h3C1;
    localparam logic [WIDX_W-1:0] W_ID_FIRST = 10'h3F4;

    // Control word: bit1 reset enable, bit0 interrupt enable
    typedef struct packed {
        logic rst_en;
        logic int_en;
    } wdt_ctrl_t;

    // Test output word: bit1 interrupt, bit0 reset
    typedef struct packed {
        logic force_int;
        logic force_rst;
    } wdt_tout_t;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0:    b = 8'h04;
            4'd4:    b = 8'h24;
            4'd5:    b = 8'hB8;
            4'd6:    b = 8'h1B;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr_wr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             int_raw,
    output logic             rst_stat,
    output logic             running
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic step;
    logic expire;

    // A bus write takes priority over a tick in the same cycle
    assign step   = tick && running && !load_wr && !clr_wr;
    assign expire = step && (count == CNT_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload   <= CNT_MAX;
            count    <= CNT_MAX;
            int_raw  <= 1'b0;
            rst_stat <= 1'b0;
            running  <= 1'b1;
        end else begin
            if (load_wr) begin
                reload  <= load_val;
                count   <= load_val;
                running <= 1'b1;
            end else if (clr_wr) begin
                count <= reload;
            end else if (step) begin
                if (count == '0) count <= reload;
                else             count <= count - CNT_ONE;
            end

            if (clr_wr)      int_raw <= 1'b0;
            else if (expire) int_raw <= 1'b1;

            if (expire && int_raw) begin
                rst_stat <= 1'b1;
                running  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wdt_apb_regs.sv
module wdt_apb_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter bit STICKY_IE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [BUS_W-1:0]  pwdata,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  reload,
    input  logic              int_raw,
    output logic [BUS_W-1:0]  prdata,
    output logic              load_wr,
    output logic [CNT_W-1:0]  load_val,
    output logic              clr_wr,
    output wdt_ctrl_t         ctrl,
    output logic              test_en,
    output wdt_tout_t         tout,
    output logic              locked
);

    localparam bit HAS_TEST = !STICKY_IE;

    logic [WIDX_W-1:0] widx;
    logic              wr_acc;
    logic              wr_open;
    logic              ctrl_wr;
    logic [BUS_W-1:0]  rd;
    logic [1:0]        unused_lsb;

    assign widx       = paddr[ADDR_W-1:2];
    assign unused_lsb = paddr[1:0];
    assign wr_acc     = psel && penable && pwrite;
    assign wr_open    = wr_acc && !locked;

    assign load_wr  = wr_open && (widx == W_LOAD);
    assign load_val = pwdata[CNT_W-1:0];
    assign clr_wr   = wr_open && (widx == W_ICLR);
    assign ctrl_wr  = wr_open && (widx == W_CTRL) && !(STICKY_IE && ctrl.int_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            locked <= 1'b0;
        end else begin
            if (ctrl_wr)
                ctrl <= wdt_ctrl_t'(pwdata[1:0]);
            if (wr_acc && (widx == W_LOCK))
                locked <= (pwdata != UNLOCK_KEY);
        end
    end

    generate
        if (HAS_TEST) begin : g_test
            always_ff @(posedge clk) begin
                if (rst) begin
                    test_en <= 1'b0;
                    tout    <= '0;
                end else begin
                    if (wr_open && (widx == W_TCTRL)) test_en <= pwdata[0];
                    if (wr_open && (widx == W_TOUT))  tout    <= wdt_tout_t'(pwdata[1:0]);
                end
            end
        end else begin : g_no_test
            assign test_en = 1'b0;
            assign tout    = '0;
        end
    endgenerate

    always_comb begin
        rd = '0;
        case (widx)
            W_LOAD:   rd = BUS_W'(reload);
            W_VALUE:  rd = BUS_W'(count);
            W_CTRL:   rd = BUS_W'(ctrl);
            W_RAW:    rd = BUS_W'(int_raw);
            W_MASKED: rd = BUS_W'(int_raw && ctrl.int_en);
            W_LOCK:   rd = BUS_W'(locked);
            W_TCTRL:  rd = HAS_TEST ? BUS_W'(test_en) : '0;
            default: begin
                if (widx >= W_ID_FIRST)
                    rd = BUS_W'(id_byte(widx[3:0] - 4'd4));
            end
        endcase
    end

    assign prdata = psel ? rd : '0;

endmodule

// File: rtl/wdt_outmux.sv
module wdt_outmux
    import wdt_pkg::*;
(
    input  wdt_ctrl_t ctrl,
    input  logic      test_en,
    input  wdt_tout_t tout,
    input  logic      int_raw,
    input  logic      rst_stat,
    output logic      irq,
    output logic      rst_req
);

    always_comb begin
        if (test_en) begin
            irq     = tout.force_int;
            rst_req = tout.force_rst;
        end else begin
            irq     = int_raw && ctrl.int_en;
            rst_req = rst_stat && ctrl.rst_en;
        end
    end

endmodule

// File: rtl/apb_watchdog.sv
module apb_watchdog
    import wdt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter bit STICKY_IE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [BUS_W-1:0]  pwdata,
    output logic [BUS_W-1:0]  prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              wdog_tick,
    output logic              irq,
    output logic              rst_req
);

    logic             load_wr;
    logic [CNT_W-1:0] load_val;
    logic             clr_wr;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] reload;
    logic             int_raw;
    logic             rst_stat;
    logic             running;
    wdt_ctrl_t        ctrl;
    logic             test_en;
    wdt_tout_t        tout;
    logic             locked;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    wdt_apb_regs #(.CNT_W(CNT_W), .STICKY_IE(STICKY_IE)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .count    (count),
        .reload   (reload),
        .int_raw  (int_raw),
        .prdata   (prdata),
        .load_wr  (load_wr),
        .load_val (load_val),
        .clr_wr   (clr_wr),
        .ctrl     (ctrl),
        .test_en  (test_en),
        .tout     (tout),
        .locked   (locked)
    );

    wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (wdog_tick),
        .load_wr  (load_wr),
        .load_val (load_val),
        .clr_wr   (clr_wr),
        .count    (count),
        .reload   (reload),
        .int_raw  (int_raw),
        .rst_stat (rst_stat),
        .running  (running)
    );

    wdt_outmux u_out (
        .ctrl     (ctrl),
        .test_en  (test_en),
        .tout     (tout),
        .int_raw  (int_raw),
        .rst_stat (rst_stat),
        .irq      (irq),
        .rst_req  (rst_req)
    );

endmodule

// File: rtl/wdt_sva.sv
module wdt_sva #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             psel,
    input logic             penable,
    input logic             pwrite,
    input logic             load_wr,
    input logic [CNT_W-1:0] load_val,
    input logic             clr_wr,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload,
    input logic             int_raw,
    input logic             rst_stat,
    input logic             running,
    input logic             locked
);

    logic quiet_step;
    assign quiet_step = tick && running && !load_wr && !clr_wr;

    // R2: a load write sets the count and restarts the counter
    a_r2_load_sets_count: assert property (@(posedge clk) disable iff (rst)
        load_wr |=> (count == $past(load_val)) && running);

    // R3: no tick and no write, the count holds
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load_wr && !clr_wr) |=> $stable(count));

    // R3: a tick on a non-zero count steps down by one
    a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
        (quiet_step && count != '0) |=> count == $past(count) - CNT_W'(1));

    // R4: first expiry raises raw status
    a_r4_first_expiry: assert property (@(posedge clk) disable iff (rst)
        (quiet_step && count == CNT_W'(1) && !int_raw) |=> int_raw && count == '0);

    // R5: second expiry latches reset status and stops
    a_r5_second_expiry: assert property (@(posedge clk) disable iff (rst)
        (quiet_step && count == CNT_W'(1) && int_raw) |=> rst_stat && !running && count == '0);

    // R5: reset status holds until block reset
    a_r5_reset_sticky: assert property (@(posedge clk) disable iff (rst)
        rst_stat |=> rst_stat);

    // R6: clear write drops raw status and reloads
    a_r6_clear_reloads: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> !int_raw && count == $past(reload));

    // R8: nothing reaches the counter while locked
    a_r8_locked_blocks: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite && locked) |-> !load_wr && !clr_wr);

endmodule

bind apb_watchdog wdt_sva #(.CNT_W(CNT_W)) u_sva (
    .clk      (clk),
    .rst      (rst),
    .tick     (wdog_tick),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .load_wr  (load_wr),
    .load_val (load_val),
    .clr_wr   (clr_wr),
    .count    (count),
    .reload   (reload),
    .int_raw  (int_raw),
    .rst_stat (rst_stat),
    .running  (running),
    .locked   (locked)
);

// File: tb/test_apb_watchdog.sv
module test_apb_watchdog;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_a = 1'b0;
    logic        sel_b = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic        tick = 1'b0;
    logic [31:0] prdata_a, prdata_b;
    logic        pready_a, pslverr_a, irq_a, rst_req_a;
    logic        pready_b, pslverr_b, irq_b, rst_req_b;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        string       req;
        logic [31:0] exp;
        bit          on_b;
        logic [11:0] addr;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    apb_watchdog i_apb_watchdog (
        .clk(clk), .rst(rst), .psel(sel_a), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_a), .pready(pready_a),
        .pslverr(pslverr_a), .wdog_tick(tick), .irq(irq_a), .rst_req(rst_req_a)
    );

    apb_watchdog #(.STICKY_IE(1'b1)) i_apb_watchdog_sticky (
        .clk(clk), .rst(rst), .psel(sel_b), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata_b), .pready(pready_b),
        .pslverr(pslverr_b), .wdog_tick(tick), .irq(irq_b), .rst_req(rst_req_b)
    );

    // Monitor: compare read data in the access phase, away from the edge
    always @(negedge clk) begin
        if ((sel_a || sel_b) && penable && !pwrite) begin
            logic [31:0] act;
            exp_t        it;
            n_vec++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: unexpected read actual=%h expected=none", prdata_a);
            end else begin
                it  = sb_q.pop_front();
                act = it.on_b ? prdata_b : prdata_a;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: read %h actual=%h expected=%h", it.req, it.addr, act, it.exp);
                end
            end
            if (!(it.on_b ? (pready_b && !pslverr_b) : (pready_a && !pslverr_a))) begin
                n_bad++;
                $display("FAIL R13: ready/err actual=%b%b expected=10",
                         it.on_b ? pready_b : pready_a, it.on_b ? pslverr_b : pslverr_a);
            end
        end
    end

    // All tasks start and end at posedge + 1
    task automatic wr(input bit b, input logic [11:0] a, input logic [31:0] d);
        sel_a = !b; sel_b = b; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(posedge clk); #1 penable = 1'b1;
        @(posedge clk); #1 sel_a = 1'b0; sel_b = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input bit b, input logic [11:0] a, input logic [31:0] e, input string req);
        exp_t it;
        it.req = req; it.exp = e; it.on_b = b; it.addr = a;
        sb_q.push_back(it);
        sel_a = !b; sel_b = b; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(posedge clk); #1 penable = 1'b1;
        @(posedge clk); #1 sel_a = 1'b0; sel_b = 1'b0; penable = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic pin(input string req, input logic act, input logic e);
        n_vec++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: pin actual=%b expected=%b", req, act, e);
        end
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: run hung actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(0, 12'h004, 32'hFFFF_FFFF, "R1");
        rd(0, 12'h000, 32'hFFFF_FFFF, "R1");
        rd(0, 12'h008, 32'h0, "R1");
        rd(0, 12'h010, 32'h0, "R1");
        rd(0, 12'hC00, 32'h0, "R1");
        pin("R1 irq", irq_a, 1'b0);
        pin("R1 rst_req", rst_req_a, 1'b0);

        // R10 identification bytes
        rd(0, 12'hFD0, 32'h04, "R10");
        rd(0, 12'hFDC, 32'h00, "R10");
        rd(0, 12'hFE0, 32'h24, "R10");
        rd(0, 12'hFE4, 32'hB8, "R10");
        rd(0, 12'hFE8, 32'h1B, "R10");
        rd(0, 12'hFF0, 32'h0D, "R10");
        rd(0, 12'hFF4, 32'hF0, "R10");
        rd(0, 12'hFFC, 32'hB1, "R10");

        // R2 load, R3 pacing
        wr(0, 12'h000, 32'd5);
        rd(0, 12'h004, 32'd5, "R2");
        rd(0, 12'h000, 32'd5, "R2");
        ticks(3);
        rd(0, 12'h004, 32'd2, "R3");
        repeat (4) @(posedge clk);
        #1 rd(0, 12'h004, 32'd2, "R3");

        // R4 first expiry and reload, R7 masking
        wr(0, 12'h008, 32'h3);
        ticks(2);
        rd(0, 12'h004, 32'd0, "R4");
        rd(0, 12'h010, 32'd1, "R4");
        rd(0, 12'h014, 32'd1, "R7");
        pin("R7 irq", irq_a, 1'b1);
        pin("R4 no reset yet", rst_req_a, 1'b0);
        ticks(1);
        rd(0, 12'h004, 32'd5, "R4");

        // R6 clear part-way down
        ticks(2);
        wr(0, 12'h00C, 32'h0);
        rd(0, 12'h010, 32'd0, "R6");
        rd(0, 12'h004, 32'd5, "R6");
        pin("R6 irq", irq_a, 1'b0);

        // R5 two expiries in a row
        ticks(5);
        pin("R4 irq", irq_a, 1'b1);
        pin("R5 not yet", rst_req_a, 1'b0);
        ticks(1);
        ticks(5);
        pin("R5 rst_req", rst_req_a, 1'b1);
        ticks(3);
        rd(0, 12'h004, 32'd0, "R5");

        // R7 enables
        wr(0, 12'h008, 32'h1);
        pin("R7 rst masked", rst_req_a, 1'b0);
        pin("R7 irq", irq_a, 1'b1);
        wr(0, 12'h008, 32'h2);
        pin("R7 irq masked", irq_a, 1'b0);
        pin("R5 sticky", rst_req_a, 1'b1);
        rd(0, 12'h014, 32'd0, "R7");
        rd(0, 12'h010, 32'd1, "R7");

        // R2 restart after stop
        wr(0, 12'h000, 32'd4);
        ticks(1);
        rd(0, 12'h004, 32'd3, "R2");
        pin("R5 sticky after load", rst_req_a, 1'b1);

        // R11 invalid and read-only
        rd(0, 12'h00C, 32'h0, "R11");
        rd(0, 12'h200, 32'h0, "R11");
        wr(0, 12'h004, 32'd9);
        rd(0, 12'h004, 32'd3, "R11");
        wr(0, 12'h010, 32'h0);
        rd(0, 12'h010, 32'd1, "R11");

        // R9 test overrides
        wr(0, 12'hF04, 32'h2);
        wr(0, 12'hF00, 32'h1);
        pin("R9 irq forced", irq_a, 1'b1);
        pin("R9 rst forced low", rst_req_a, 1'b0);
        rd(0, 12'hF00, 32'h1, "R9");
        rd(0, 12'hF04, 32'h0, "R9");
        wr(0, 12'hF04, 32'h1);
        pin("R9 irq forced low", irq_a, 1'b0);
        pin("R9 rst forced", rst_req_a, 1'b1);
        wr(0, 12'hF04, 32'h2);
        wr(0, 12'hF00, 32'h0);
        pin("R9 normal irq", irq_a, 1'b0);
        pin("R9 normal rst", rst_req_a, 1'b1);

        // R8 lock
        wr(0, 12'hC00, 32'h1ACC_E550);
        rd(0, 12'hC00, 32'h1, "R8");
        wr(0, 12'h000, 32'd9);
        rd(0, 12'h000, 32'd4, "R8");
        wr(0, 12'h008, 32'h3);
        rd(0, 12'h008, 32'h2, "R8");
        wr(0, 12'h00C, 32'h0);
        rd(0, 12'h010, 32'd1, "R8");
        wr(0, 12'hC00, 32'h1ACC_E551);
        rd(0, 12'hC00, 32'h0, "R8");
        wr(0, 12'h008, 32'h3);
        rd(0, 12'h008, 32'h3, "R8");
        pin("R8 irq after unlock", irq_a, 1'b1);

        // R12 sticky variant
        wr(1, 12'h008, 32'h2);
        rd(1, 12'h008, 32'h2, "R12");
        wr(1, 12'h008, 32'h1);
        rd(1, 12'h008, 32'h1, "R12");
        wr(1, 12'h008, 32'h0);
        rd(1, 12'h008, 32'h1, "R12");
        wr(1, 12'hF04, 32'h2);
        wr(1, 12'hF00, 32'h1);
        rd(1, 12'hF00, 32'h0, "R12");
        pin("R12 no override", irq_b, 1'b0);
        rd(1, 12'h00C, 32'h0, "R12");
        rd(1, 12'hFE0, 32'h24, "R10");

        repeat (2) @(posedge clk);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: pending actual=%0d expected=0", sb_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule